// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels owns a shared internal bus. Each channel raises a request bit. The arbiter awards the bus to one channel and keeps it there until that channel signals the end of its transfer with a one-cycle done pulse. Only then does the arbiter look at the requests again.

A single mode input selects the ordering used for each new award. In strict mode the lowest-numbered requesting channel always wins. In rotating mode the channel that completed the most recent transfer drops to the back of the queue, and the channel numbered just after it comes first. The mode may change at run time. The record of the last-served channel is kept up to date in both modes, so a switch into rotating mode continues from the true history.

Requesters are expected to hold their request bit from the moment they assert it until their own done pulse. The grant comes from a register. Decisions are taken only on clock edges at which the bus is idle.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, `bus_gnt_o` is 4'b0000 and `gnt_chan_o` is 0. The last-served record resets to channel 3.
- R2: `bus_gnt_o` is always one-hot or all zero. Any set bit belongs to a channel whose request bit is set.
- R3: With `rotate_en_i` = 0, a decision awards the bus to the lowest-numbered requesting channel (0 beats 1, 1 beats 2, 2 beats 3).
- R4: With `rotate_en_i` = 1, after channel c was last served, a decision searches the channels in the order c+1, c+2, c+3, c (modulo 4) and awards the first one that is requesting.
- R5: Directly after reset, the rotating order is 0, 1, 2, 3.
- R6: Once awarded, the grant stays on the same channel, whatever the other request bits do, until a done pulse arrives.
- R7: When the bus is idle, a decision at a clock edge makes the grant visible after that edge. The edge that samples `xfer_done_i` = 1 clears the grant. The next decision is taken at the edge that follows.
- R8: No grant is issued while the request vector is all zero.
- R9: The last-served record takes the granted channel's number only at an edge where `xfer_done_i` = 1 and a grant is held. This happens in either mode. A done pulse while idle leaves the record unchanged.
- R10: `gnt_chan_o` carries the binary number of the channel whose `bus_gnt_o` bit is set. It is 0 when no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req_i | input | 4 | Request bit per channel, bit n for channel n |
| rotate_en_i | input | 1 | 0 selects strict order, 1 selects rotating order |
| xfer_done_i | input | 1 | One-cycle pulse: the granted channel has finished |
| bus_gnt_o | output | 4 | One-hot grant, bit n for channel n |
| gnt_chan_o | output | 2 | Binary number of the granted channel |

## Verification
The hardest state to reach is a given last-served channel combined with a given request pattern in rotating mode. The history is only visible through later rotating decisions. The bench reaches each of the four history values by running one complete transfer on a single channel with strict mode selected. This also shows that the record updates outside rotating mode. It then presents all fifteen non-zero request patterns in both modes and compares each award with an order computed arithmetically. A separate sequence sends a done pulse while the bus is idle, and then shows through a rotating decision that the history did not move.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    PRIO_STRICT = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/arb_last_ptr.sv
module arb_last_ptr #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [IDX_W-1:0] last_idx
);

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] last_d;

  always_comb begin
    last_d = last_q;
    if (upd_en) begin
      last_d = upd_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDX_W'(NUM_CH - 1);
    end else if (upd_en) begin
      last_q <= last_d;
    end
  end

  assign last_idx = last_q;

  // R9
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (last_q == $past(upd_idx)));

  // R9
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(last_q));

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  prio_mode_e        mode,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              pick_vld,
  output logic [IDX_W-1:0]  pick_idx
);

  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] cand;

  always_comb begin
    if (mode == PRIO_ROTATE) begin
      start_idx = last_idx + IDX_W'(1);
    end else begin
      start_idx = '0;
    end
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    cand     = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      cand = start_idx + IDX_W'(k);
      if (req[cand]) begin
        pick_vld = 1'b1;
        pick_idx = cand;
      end
    end
  end

  // R2
  pick_req_chk: assert final (!pick_vld || req[pick_idx]);

  // R8
  pick_none_chk: assert final (pick_vld == (|req));

endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_vld,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic              done,
  output logic [NUM_CH-1:0] gnt,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic              busy
);

  logic [NUM_CH-1:0] gnt_q;
  logic [NUM_CH-1:0] gnt_d;
  logic [NUM_CH-1:0] gnt_en;

  assign busy = |gnt_q;

  always_comb begin
    gnt_d = gnt_q;
    if (!busy) begin
      if (pick_vld) begin
        gnt_d = NUM_CH'(1) << pick_idx;
      end
    end else if (done) begin
      gnt_d = '0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_gnt_bit
    assign gnt_en[c] = (!busy && pick_vld) || (busy && done);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gnt_q[c] <= 1'b0;
      end else if (gnt_en[c]) begin
        gnt_q[c] <= gnt_d[c];
      end
    end
  end

  always_comb begin
    gnt_idx = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (gnt_q[c]) begin
        gnt_idx = gnt_idx | IDX_W'(c);
      end
    end
  end

  assign gnt = gnt_q;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (gnt_q == $past(gnt_q)));

  // R7
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> (gnt_q == '0));

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int RST_STAGES = 2,
  localparam int IDX_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_req_i,
  input  logic              rotate_en_i,
  input  logic              xfer_done_i,
  output logic [NUM_CH-1:0] bus_gnt_o,
  output logic [IDX_W-1:0]  gnt_chan_o
);

  logic             rst_sync_n;
  prio_mode_e       mode;
  logic [IDX_W-1:0] last_idx;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic             busy;
  logic             ptr_upd;

  assign mode    = prio_mode_e'(rotate_en_i);
  assign ptr_upd = busy && xfer_done_i;

  arb_rst_sync #(
    .STAGES     (RST_STAGES)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arb_last_ptr #(
    .NUM_CH   (NUM_CH)
  ) i_last_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (ptr_upd),
    .upd_idx  (gnt_chan_o),
    .last_idx (last_idx)
  );

  arb_pick #(
    .NUM_CH   (NUM_CH)
  ) i_pick (
    .req      (chan_req_i),
    .mode     (mode),
    .last_idx (last_idx),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  arb_grant_hold #(
    .NUM_CH   (NUM_CH)
  ) i_grant_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx),
    .done     (xfer_done_i),
    .gnt      (bus_gnt_o),
    .gnt_idx  (gnt_chan_o),
    .busy     (busy)
  );

  // R8
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && chan_req_i == '0) |=> (bus_gnt_o == '0));

  // R7
  idle_award_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && chan_req_i != '0) |=> (bus_gnt_o != '0));

  // R2
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_gnt_o & ~chan_req_i) == '0));

  // R10
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_gnt_o == '0) ? (gnt_chan_o == '0) : bus_gnt_o[gnt_chan_o]);

endmodule

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       rot;
  logic       done;
  logic [3:0] gnt;
  logic [1:0] gidx;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_req_i  (req),
    .rotate_en_i (rot),
    .xfer_done_i (done),
    .bus_gnt_o   (gnt),
    .gnt_chan_o  (gidx)
  );

  function automatic int exp_pick(logic [3:0] pat, bit m, int last);
    int start = m ? (last + 1) % 4 : 0;
    for (int k = 0; k < 4; k++) begin
      int c = (start + k) % 4;
      if (pat[c]) return c;
    end
    return -1;
  endfunction

  task automatic chk(string rq, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_xfer();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    req  = 4'b0000;
    @(negedge clk);
  endtask

  // one full transfer on channel ch in strict mode: sets the history to ch
  task automatic serve(int ch);
    rot = 1'b0;
    req = 4'b0001 << ch;
    @(negedge clk);
    chk("R3 single requester", int'(gnt), 1 << ch);
    finish_xfer();
  endtask

  initial begin
    rst_n = 1'b0;
    req   = 4'b0000;
    rot   = 1'b0;
    done  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", int'(gnt), 0);
    chk("R1 index in reset", int'(gidx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 grant after reset", int'(gnt), 0);
    chk("R8 no request no grant", int'(gnt), 0);

    // R5: rotating order straight after reset starts at channel 0
    rot = 1'b1;
    req = 4'b1111;
    @(negedge clk);
    chk("R5 first rotating award", int'(gnt), 1);
    chk("R10 index ch0", int'(gidx), 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R7 grant cleared at done edge", int'(gnt), 0);
    @(negedge clk);
    chk("R4 after ch0 comes ch1", int'(gnt), 2);
    chk("R10 index ch1", int'(gidx), 1);
    finish_xfer();

    // sweep: every history value, every pattern, both modes
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 4; l++) begin
        for (int p = 1; p < 16; p++) begin
          int e;
          serve(l);
          e   = exp_pick(4'(p), m[0], l);
          rot = m[0];
          req = 4'(p);
          @(negedge clk);
          chk(m == 0 ? "R3 strict award" : "R4 R9 rotating award",
              int'(gnt), 1 << e);
          chk("R10 index", int'(gidx), e);
          chk("R2 grant within requests", int'(gnt & ~req), 0);
          finish_xfer();
        end
      end
    end

    // R6 / R7: grant held while lower channels join, then next award
    rot = 1'b0;
    req = 4'b0100;
    @(negedge clk);
    chk("R6 initial award ch2", int'(gnt), 4);
    req = 4'b0111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 grant held", int'(gnt), 4);
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R7 released on done", int'(gnt), 0);
    @(negedge clk);
    chk("R7 next award strict ch0", int'(gnt), 1);
    finish_xfer();

    // R9: done pulse while idle must not move the history
    serve(1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk("R8 idle stays idle", int'(gnt), 0);
    rot = 1'b1;
    req = 4'b1111;
    @(negedge clk);
    chk("R9 idle done ignored", int'(gnt), 4);
    finish_xfer();

    // R8: zero requests over several cycles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 zero requests", int'(gnt), 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule